// File: doc/BRIEF.md
# Dual System Clock Source Switch Controller

This controller decides which of four source clocks (RC, main, PLL, sub) feeds each of two independent system clocks. Software writes a 2-bit source code for each system clock. The controller then waits until that source reports ready. Next it points the glitch-free clock mux at the new source and runs a fixed-length synchronisation sequence. Only after that sequence ends does it update a monitor field that software reads back.

A second write to a select field before the switch finishes discards the earlier request. A wake from stop mode applies every select field at once, without checking readiness. The block also drives enables to the four oscillators. An oscillator that either system clock uses, or is about to use, is forced on; the others follow their software bits. A single access-permitted output tells software when both system clocks have settled.

The oscillators, their stabilisation timers and the clock mux itself lie outside this block. Their readiness arrives as level inputs. The RC stabilisation wait that follows reset is counted inside the block.

Top module: `sysclk_src_switch`

## Requirements
- R1: While reset is high, and on the first cycle after it, every select field, monitor field and mux select reads 00 (RC) and every pending bit reads 0.
- R2: The source enable vector uses bit 0 = RC, bit 1 = main, bit 2 = PLL, bit 3 = sub. Reset loads the software enable bits with 1011, so PLL is off.
- R3: Source codes are 00 = RC, 01 = main, 10 = PLL, 11 = sub. A write with wr_addr = i (i below NUM_SYSCLK) loads wr_data[1:0] into the select field of system clock i. A write to a value other than its monitor field shows the new select value and sets pending on the next cycle.
- R4: While the requested source is not ready, the mux select and the monitor field keep the current source and pending stays 1.
- R5: On the cycle after the target is seen ready, the mux select takes the new code. The monitor field takes it 4 cycles later (SYNC_CYCLES), and pending drops in that same cycle.
- R6: The two system clocks switch independently. A request or switch on one leaves the fields of the other unchanged.
- R7: A write during a pending or in-progress switch abandons that switch. The mux select returns to the monitor value on the next cycle, and only the newest select value is pursued.
- R8: A write whose value equals the current monitor field clears pending on the next cycle and leaves the mux select unchanged.
- R9: A stop_release pulse, with no write in the same cycle, sets every monitor field and mux select to its select value on the next cycle and clears pending, whatever the ready inputs show.
- R10: After reset, RC counts as ready only once RC_STAB_CYCLES cycles have passed, even if its ready input is high.
- R11: A source named by any select field, monitor field or mux select is enabled one cycle later, whatever its software bit. Other sources follow the bits written with wr_addr = NUM_SYSCLK, and those bits reach src_en two cycles after the write.
- R12: access_ok is high exactly when every monitor field equals its select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0..NUM_SYSCLK-1: select field of that system clock; NUM_SYSCLK: enable bits |
| wr_data | input | 4 | Write data (bits 1:0 for selects, 3:0 for enables) |
| src_rdy | input | 4 | Ready flags of RC, main, PLL, sub (bit order as R2) |
| stop_release | input | 1 | One-cycle pulse on wake from stop mode |
| sel_rb | output | 2*NUM_SYSCLK | Select field readback, clock i at bits 2i+1:2i |
| mon | output | 2*NUM_SYSCLK | Monitor fields, clock i at bits 2i+1:2i |
| mux_sel | output | 2*NUM_SYSCLK | Select lines to the clock muxes |
| pending | output | NUM_SYSCLK | Switch pending per system clock |
| src_en | output | 4 | Oscillator enables |
| access_ok | output | 1 | All system clocks settled |

## Verification
The assertions assume that wr_addr never points past the enable slot and that stop_release is a single-cycle pulse. They also treat the ready inputs as free to change on any cycle, so a property about a source not being ready holds only for the cycles in which its flag is low. The stimulus changes ready flags and pulses only on the falling clock edge. It never issues a write in the same cycle as stop_release, which keeps the case in which the write takes priority out of the properties that describe the wake.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_SUB  = 2'd3
  } src_e;

  localparam int NUM_SRC = 4;
  localparam int SRC_W   = 2;
  localparam logic [NUM_SRC-1:0] EN_RESET = 4'b1011;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_SYNC = 2'd2
  } ch_state_e;
endpackage

// File: rtl/clksw_rc_stab.sv
module clksw_rc_stab #(
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/clksw_chan.sv
module clksw_chan
  import clksw_pkg::*;
#(
  parameter int SYNC_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [SRC_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] rdy_vec,
  input  logic               stop_rel,
  output logic [SRC_W-1:0]   sel_q,
  output logic [SRC_W-1:0]   mon_q,
  output logic [SRC_W-1:0]   mux_q,
  output logic               pending
);
  localparam int CW = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_CYCLES - 1);

  ch_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      sel_q   <= SRC_RC;
      mon_q   <= SRC_RC;
      mux_q   <= SRC_RC;
      cnt_q   <= '0;
    end else if (wr) begin
      // a new request always drops whatever was under way
      sel_q   <= wdata;
      mux_q   <= mon_q;
      cnt_q   <= '0;
      state_q <= (wdata == mon_q) ? CH_IDLE : CH_WAIT;
    end else if (stop_rel) begin
      mux_q   <= sel_q;
      mon_q   <= sel_q;
      cnt_q   <= '0;
      state_q <= CH_IDLE;
    end else begin
      case (state_q)
        CH_WAIT: begin
          if (rdy_vec[sel_q]) begin
            mux_q   <= sel_q;
            cnt_q   <= '0;
            state_q <= CH_SYNC;
          end
        end
        CH_SYNC: begin
          if (cnt_q == LAST) begin
            mon_q   <= sel_q;
            state_q <= CH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign pending = (state_q != CH_IDLE);
endmodule

// File: rtl/clksw_src_en.sv
module clksw_src_en
  import clksw_pkg::*;
#(
  parameter int NUM_SYSCLK = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en_wr,
  input  logic [NUM_SRC-1:0]          en_wdata,
  input  logic [SRC_W*NUM_SYSCLK-1:0] sel_all,
  input  logic [SRC_W*NUM_SYSCLK-1:0] mon_all,
  input  logic [SRC_W*NUM_SYSCLK-1:0] mux_all,
  output logic [NUM_SRC-1:0]          src_en
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] in_use;

  always_comb begin
    in_use = '0;
    for (int i = 0; i < NUM_SYSCLK; i++) begin
      in_use[sel_all[SRC_W*i +: SRC_W]] = 1'b1;
      in_use[mon_all[SRC_W*i +: SRC_W]] = 1'b1;
      in_use[mux_all[SRC_W*i +: SRC_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= EN_RESET;
      src_en <= EN_RESET;
    end else begin
      if (en_wr) en_q <= en_wdata;
      src_en <= en_q | in_use;
    end
  end
endmodule

// File: rtl/sysclk_src_switch.sv
module sysclk_src_switch
  import clksw_pkg::*;
#(
  parameter int NUM_SYSCLK     = 2,
  parameter int SYNC_CYCLES    = 4,
  parameter int RC_STAB_CYCLES = 64,
  parameter int ADDR_W         = $clog2(NUM_SYSCLK + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [3:0]                  wr_data,
  input  logic [3:0]                  src_rdy,
  input  logic                        stop_release,
  output logic [2*NUM_SYSCLK-1:0]     sel_rb,
  output logic [2*NUM_SYSCLK-1:0]     mon,
  output logic [2*NUM_SYSCLK-1:0]     mux_sel,
  output logic [NUM_SYSCLK-1:0]       pending,
  output logic [3:0]                  src_en,
  output logic                        access_ok
);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NUM_SYSCLK);

  logic               rc_done;
  logic [NUM_SRC-1:0] rdy_eff;
  logic [NUM_SYSCLK-1:0] settled;

  clksw_rc_stab #(.STAB_CYCLES(RC_STAB_CYCLES)) u_rc_stab (
    .clk  (clk),
    .rst  (rst),
    .done (rc_done)
  );

  assign rdy_eff = {src_rdy[3:1], src_rdy[0] & rc_done};

  for (genvar g = 0; g < NUM_SYSCLK; g++) begin : g_chan
    logic ch_wr;
    assign ch_wr = wr_en && (wr_addr == ADDR_W'(g));

    clksw_chan #(.SYNC_CYCLES(SYNC_CYCLES)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr       (ch_wr),
      .wdata    (wr_data[SRC_W-1:0]),
      .rdy_vec  (rdy_eff),
      .stop_rel (stop_release),
      .sel_q    (sel_rb[SRC_W*g +: SRC_W]),
      .mon_q    (mon[SRC_W*g +: SRC_W]),
      .mux_q    (mux_sel[SRC_W*g +: SRC_W]),
      .pending  (pending[g])
    );

    assign settled[g] = (mon[SRC_W*g +: SRC_W] == sel_rb[SRC_W*g +: SRC_W]);
  end

  clksw_src_en #(.NUM_SYSCLK(NUM_SYSCLK)) u_src_en (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (wr_en && (wr_addr == EN_ADDR)),
    .en_wdata (wr_data),
    .sel_all  (sel_rb),
    .mon_all  (mon),
    .mux_all  (mux_sel),
    .src_en   (src_en)
  );

  assign access_ok = &settled;
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker #(
  parameter int NUM_SYSCLK = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic                    stop_release,
  input logic [3:0]              src_rdy,
  input logic [2*NUM_SYSCLK-1:0] sel_rb,
  input logic [2*NUM_SYSCLK-1:0] mon,
  input logic [2*NUM_SYSCLK-1:0] mux_sel,
  input logic [NUM_SYSCLK-1:0]   pending,
  input logic [3:0]              src_en,
  input logic                    access_ok
);
  for (genvar g = 0; g < NUM_SYSCLK; g++) begin : g_chk
    AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (rst)
      !pending[g] |-> (mon[2*g +: 2] == sel_rb[2*g +: 2]) && (mux_sel[2*g +: 2] == mon[2*g +: 2])); // R5

    AST_MON_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
      !$stable(mon[2*g +: 2]) |-> (mon[2*g +: 2] == $past(sel_rb[2*g +: 2]))); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      pending[g] && !src_rdy[sel_rb[2*g +: 2]] && !stop_release && !wr_en
      |=> $stable(mux_sel[2*g +: 2])); // R4

    AST_STOP_APPLY: assert property (@(posedge clk) disable iff (rst)
      stop_release && !wr_en |=> !pending[g] && (mon[2*g +: 2] == sel_rb[2*g +: 2])); // R9

    AST_FORCED_EN: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> src_en[$past(mux_sel[2*g +: 2])] && src_en[$past(mon[2*g +: 2])]); // R11
  end

  AST_ACCESS_SETTLED: assert property (@(posedge clk) disable iff (rst)
    access_ok |-> (pending == '0)); // R12
endmodule

bind sysclk_src_switch clksw_checker #(.NUM_SYSCLK(NUM_SYSCLK)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .stop_release (stop_release),
  .src_rdy      (src_rdy),
  .sel_rb       (sel_rb),
  .mon          (mon),
  .mux_sel      (mux_sel),
  .pending      (pending),
  .src_en       (src_en),
  .access_ok    (access_ok)
);

// File: tb/sysclk_src_switch_tb.sv
module sysclk_src_switch_tb;
  localparam int N      = 2;
  localparam int AW     = $clog2(N + 1);
  localparam int STAB   = 64;

  localparam int F_MON = 0, F_SEL = 1, F_MUX = 2, F_PEND = 3, F_EN = 4, F_ACC = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_data = '0;
  logic [3:0]    src_rdy = 4'b1011;
  logic          stop_release = 1'b0;
  logic [2*N-1:0] sel_rb, mon, mux_sel;
  logic [N-1:0]  pending;
  logic [3:0]    src_en;
  logic          access_ok;

  always #5 clk = ~clk;

  sysclk_src_switch #(.NUM_SYSCLK(N), .SYNC_CYCLES(4), .RC_STAB_CYCLES(STAB)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_rdy(src_rdy), .stop_release(stop_release), .sel_rb(sel_rb), .mon(mon),
    .mux_sel(mux_sel), .pending(pending), .src_en(src_en), .access_ok(access_ok)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    int         fld;
    int         ch;
    logic [3:0] exp;
    string      req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [3:0] observe(int fld, int ch);
    case (fld)
      F_MON:  return {2'b00, mon[2*ch +: 2]};
      F_SEL:  return {2'b00, sel_rb[2*ch +: 2]};
      F_MUX:  return {2'b00, mux_sel[2*ch +: 2]};
      F_PEND: return {3'b000, pending[ch]};
      F_EN:   return src_en;
      default: return {3'b000, access_ok};
    endcase
  endfunction

  task automatic expect_at(int due, int fld, int ch, logic [3:0] v, string req);
    exp_t e;
    e.due = due; e.fld = fld; e.ch = ch; e.exp = v; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].due == cyc) begin
        logic [3:0] got;
        got = observe(q[k].fld, q[k].ch);
        n_chk++;
        if (got !== q[k].exp) begin
          n_fail++;
          $display("FAIL %s field %0d clk %0d cycle %0d: actual %b expected %b",
                   q[k].req, q[k].fld, q[k].ch, cyc, got, q[k].exp);
        end
        q.delete(k);
      end
    end
  end

  task automatic goto(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr_start(int addr, logic [3:0] data, output int c);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data; c = cyc;
  endtask

  task automatic wr_finish();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c, c2, c0, d, s, r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    c0 = cyc;
    // R1 / R2 reset state
    expect_at(c0 + 1, F_MON, 0, 4'd0, "R1");
    expect_at(c0 + 1, F_MON, 1, 4'd0, "R1");
    expect_at(c0 + 1, F_SEL, 1, 4'd0, "R1");
    expect_at(c0 + 1, F_MUX, 0, 4'd0, "R1");
    expect_at(c0 + 1, F_PEND, 0, 4'd0, "R1");
    expect_at(c0 + 1, F_EN, 0, 4'b1011, "R2");
    expect_at(c0 + 1, F_ACC, 0, 4'd1, "R12");
    @(negedge clk);

    // R3 / R5: clock 0 to main, main ready
    wr_start(0, 4'd1, c);
    expect_at(c + 1, F_SEL, 0, 4'd1, "R3");
    expect_at(c + 1, F_PEND, 0, 4'd1, "R3");
    expect_at(c + 1, F_MUX, 0, 4'd0, "R5");
    expect_at(c + 2, F_MUX, 0, 4'd1, "R5");
    expect_at(c + 3, F_ACC, 0, 4'd0, "R12");
    expect_at(c + 5, F_MON, 0, 4'd0, "R5");
    expect_at(c + 6, F_MON, 0, 4'd1, "R5");
    expect_at(c + 6, F_PEND, 0, 4'd0, "R5");
    expect_at(c + 6, F_ACC, 0, 4'd1, "R12");
    wr_finish();

    // R10: back to RC before its stabilisation wait is over
    goto(c + 8);
    wr_start(0, 4'd0, c);
    expect_at(c + 8, F_MON, 0, 4'd1, "R10");
    expect_at(c + 8, F_PEND, 0, 4'd1, "R10");
    expect_at(c0 + STAB + 4, F_MON, 0, 4'd1, "R10");
    expect_at(c0 + STAB + 5, F_MON, 0, 4'd0, "R10");
    wr_finish();

    // R4 / R6 / R11: clock 1 to PLL, not ready
    goto(c0 + STAB + 10);
    wr_start(1, 4'd2, c);
    expect_at(c + 1, F_SEL, 1, 4'd2, "R3");
    expect_at(c + 3, F_EN, 0, 4'b1111, "R11");
    expect_at(c + 10, F_PEND, 1, 4'd1, "R4");
    expect_at(c + 10, F_MON, 1, 4'd0, "R4");
    expect_at(c + 10, F_MUX, 1, 4'd0, "R4");
    wr_finish();
    goto(c + 2);
    wr_start(0, 4'd1, c2);
    expect_at(c2 + 6, F_MON, 0, 4'd1, "R6");
    expect_at(c2 + 6, F_PEND, 1, 4'd1, "R6");
    expect_at(c2 + 6, F_MON, 1, 4'd0, "R6");
    wr_finish();
    goto(c + 15);
    src_rdy = 4'b1111;
    d = cyc;
    expect_at(d + 1, F_MUX, 1, 4'd2, "R5");
    expect_at(d + 4, F_MON, 1, 4'd0, "R5");
    expect_at(d + 5, F_MON, 1, 4'd2, "R5");
    expect_at(d + 5, F_PEND, 1, 4'd0, "R5");
    expect_at(d + 5, F_ACC, 0, 4'd1, "R12");

    // R7: cancel an in-progress switch, sub not ready
    goto(d + 8);
    src_rdy = 4'b0111;
    wr_start(0, 4'd2, c);
    expect_at(c + 2, F_MUX, 0, 4'd2, "R7");
    wr_finish();
    goto(c + 2);
    wr_start(0, 4'd3, c2);
    expect_at(c2 + 1, F_MUX, 0, 4'd1, "R7");
    expect_at(c2 + 1, F_SEL, 0, 4'd3, "R7");
    expect_at(c2 + 8, F_MON, 0, 4'd1, "R7");
    expect_at(c2 + 8, F_PEND, 0, 4'd1, "R7");
    wr_finish();

    // R8: cancel back to the monitored source
    goto(c2 + 10);
    wr_start(0, 4'd1, c);
    expect_at(c + 1, F_PEND, 0, 4'd0, "R8");
    expect_at(c + 1, F_MUX, 0, 4'd1, "R8");
    expect_at(c + 1, F_MON, 0, 4'd1, "R8");
    expect_at(c + 1, F_ACC, 0, 4'd1, "R8");
    wr_finish();

    // R9: stop release applies select without ready
    goto(c + 4);
    wr_start(1, 4'd3, c);
    wr_finish();
    goto(c + 3);
    stop_release = 1'b1;
    s = cyc;
    expect_at(s, F_MON, 1, 4'd2, "R9");
    expect_at(s + 1, F_MON, 1, 4'd3, "R9");
    expect_at(s + 1, F_MUX, 1, 4'd3, "R9");
    expect_at(s + 1, F_PEND, 1, 4'd0, "R9");
    @(negedge clk);
    stop_release = 1'b0;

    // R11: software enables, selected sources forced
    goto(s + 4);
    wr_start(2, 4'b0000, c);
    expect_at(c + 1, F_EN, 0, 4'b1011, "R11");
    expect_at(c + 2, F_EN, 0, 4'b1010, "R11");
    wr_finish();
    goto(c + 4);
    wr_start(2, 4'b0100, c);
    expect_at(c + 2, F_EN, 0, 4'b1110, "R11");
    wr_finish();

    // R1 / R2: reset again mid-run
    goto(c + 5);
    rst = 1'b1;
    r = cyc;
    expect_at(r + 1, F_SEL, 0, 4'd0, "R1");
    expect_at(r + 1, F_SEL, 1, 4'd0, "R1");
    expect_at(r + 1, F_MON, 0, 4'd0, "R1");
    expect_at(r + 1, F_MUX, 1, 4'd0, "R1");
    expect_at(r + 1, F_PEND, 1, 4'd0, "R1");
    expect_at(r + 1, F_EN, 0, 4'b1011, "R2");
    goto(r + 3);
    rst = 1'b0;

    goto(r + 10);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d unchecked items expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule